// File: doc/BRIEF.md
# Multi-rail power-on reset sequencer

This block turns three asynchronous power-good flags into a clean reset release for the chip. The flags come from three supply-monitor groups: a regulator group (internal configuration supply), a satellite group (pre-driver and configuration-pin supplies) and a main group (core supplies). Every flag passes through a two-flop synchronizer. The regulator result is gated into the main result, and that product is ANDed with the satellite result to form the final trip. After the trip, reset is held for a pulse width chosen by a delay-select pin. The select pin is sampled once, when the first power-good flag rises.

While the supplies come up, the block watches how quickly each group arrives. The ramp window opens when the first group's synchronized flag rises. A group that arrives late sets a sticky fault flag. A complete set that arrives suspiciously fast sets a sticky warning flag. Both flags are cleared only when every power-good flag is low again.

User I/O output enables are gated off until the block reaches user mode. User mode means that reset has been released and the configuration engine reports done. Configuration-status output enables bypass the gate, so those pins may drive during power transitions. Time is counted in ticks of a free-running clock, and the tick counts are derived from the parameter `CLK_KHZ`.

Top module: `pwr_reset_seq`

## Requirements
- R1: `por_hold_o` stays high unless all three synchronized groups (regulator bit, satellite bit, main bit) are good. Any two of them alone never release reset.
- R2: The hold pulse lasts 100 ms (100*CLK_KHZ ticks) when the latched select is 0 and 12 ms (12*CLK_KHZ ticks) when it is 1. `por_hold_o` falls PULSE+2 cycles after the last power-good input rises, where the 2 cycles come from the synchronizer.
- R3: `dly_sel_i` is captured when the first synchronized power-good flag rises. Changes to it afterwards have no effect until all flags have been low.
- R4: When a group is still not good at or after its limit, counted from the opening of the window, `ramp_fault_o` is set and stays set. The limit for the regulator group is 5 ms for either select value. The limit for the satellite and main groups is 12 ms when the select is 1 and 100 ms when it is 0.
- R5: `ramp_warn_o` is set when all three groups are good less than 50 µs (CLK_KHZ/20 ticks) after the window opens. This includes all three arriving in the same cycle.
- R6: When all three synchronized flags are low, both flags clear, the window closes and the select becomes free to be captured again.
- R7: `user_mode_o` is high only when reset has been released and `cfg_done_i` is high. `user_oe_o` equals `user_oe_i` in user mode and is all zeros otherwise.
- R8: If any group drops while in user mode, `user_mode_o` and `user_oe_o` go off, and `por_hold_o` goes high again, within 3 cycles of the input falling.
- R9: `cfg_oe_o` always equals `cfg_oe_i`, whatever the power state.
- R10: After `arst_n` reset, `por_hold_o` is 1 and `user_mode_o`, `user_oe_o`, `ramp_fault_o` and `ramp_warn_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running tick clock |
| arst_n | input | 1 | Asynchronous active-low reset of the sequencer logic |
| pg_reg_i | input | 1 | Regulator-group power-good (asynchronous) |
| pg_sat_i | input | 1 | Satellite-group power-good (asynchronous) |
| pg_main_i | input | 1 | Main-group power-good (asynchronous) |
| dly_sel_i | input | 1 | Delay select: 1 selects short pulse and ramp limits, 0 selects long |
| cfg_done_i | input | 1 | Configuration finished |
| user_oe_i | input | N_IO | Requested user I/O output enables |
| cfg_oe_i | input | 3 | Configuration-status output enables (done, status, chain-enable) |
| user_oe_o | output | N_IO | Gated user I/O output enables |
| cfg_oe_o | output | 3 | Ungated configuration-status output enables |
| por_hold_o | output | 1 | Reset held (active high) |
| user_mode_o | output | 1 | Device in user mode |
| ramp_fault_o | output | 1 | Sticky: a group arrived too late |
| ramp_warn_o | output | 1 | Sticky: the supplies arrived too fast |

## Verification
Some properties are checked on every cycle. Reset can only fall after a trip that was already present. User mode implies that reset is released. A lost trip removes user mode on the next cycle. The latched select does not move while the window is open. The fault flag is sticky, and both flags clear after a full power loss. Other behaviours can only be shown by the bench's directed scenarios: the exact pulse lengths for both select values, the ramp limit that belongs to each group, the fast-ramp warning, and the pass-through of the configuration-status enables.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int N_GRP    = 3;
  localparam int GRP_REG  = 0;
  localparam int GRP_SAT  = 1;
  localparam int GRP_MAIN = 2;

  function automatic int ms_ticks(input int clk_khz, input int ms);
    return clk_khz * ms;
  endfunction
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        meta_q[i] <= 1'b0;
        q_o[i]    <= 1'b0;
      end else begin
        meta_q[i] <= d_i[i];
        q_o[i]    <= meta_q[i];
      end
    end
  end
endmodule

// File: rtl/por_ramp_mon.sv
module por_ramp_mon
  import por_pkg::*;
#(
  parameter int MIN_T = 2,
  parameter int REG_T = 200,
  parameter int HI_T  = 480,
  parameter int LO_T  = 4000
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [N_GRP-1:0] pg_s_i,
  input  logic             sel_i,
  output logic             sel_q_o,
  output logic             fault_o,
  output logic             warn_o
);
  localparam int TW = $clog2(LO_T + 2);
  localparam logic [TW-1:0] MIN_C = TW'(MIN_T);
  localparam logic [TW-1:0] REG_C = TW'(REG_T);
  localparam logic [TW-1:0] HI_C  = TW'(HI_T);
  localparam logic [TW-1:0] LO_C  = TW'(LO_T);

  logic             active_q;
  logic [TW-1:0]    t_q;
  logic [N_GRP-1:0] seen_q;
  logic [N_GRP-1:0] late;
  logic             any_s, all_s, fast;

  assign any_s = |pg_s_i;
  assign all_s = &pg_s_i;
  assign fast  = all_s && !(&seen_q) && (!active_q || (t_q < MIN_C));

  for (genvar g = 0; g < N_GRP; g++) begin : g_lim
    logic [TW-1:0] lim;
    if (g == GRP_REG) begin : g_reg
      assign lim = REG_C;
    end else begin : g_oth
      assign lim = sel_q_o ? HI_C : LO_C;
    end
    assign late[g] = active_q && !seen_q[g] && !pg_s_i[g] && (t_q >= lim);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      active_q <= 1'b0;
      t_q      <= '0;
      seen_q   <= '0;
      sel_q_o  <= 1'b0;
      fault_o  <= 1'b0;
      warn_o   <= 1'b0;
    end else if (!any_s) begin
      active_q <= 1'b0;
      t_q      <= '0;
      seen_q   <= '0;
      fault_o  <= 1'b0;
      warn_o   <= 1'b0;
    end else begin
      if (!active_q) begin
        active_q <= 1'b1;
        sel_q_o  <= sel_i;
      end
      if (active_q && (t_q != '1)) t_q <= t_q + 1'b1;
      seen_q <= seen_q | pg_s_i;
      if (|late) fault_o <= 1'b1;
      if (fast)  warn_o  <= 1'b1;
    end
  end

  a_r4_fault_sticky: assert property (@(posedge clk) disable iff (!arst_n)
    (fault_o && any_s) |=> fault_o);
  a_r6_flags_clear: assert property (@(posedge clk) disable iff (!arst_n)
    !any_s |=> (!fault_o && !warn_o));
  a_r3_sel_held: assert property (@(posedge clk) disable iff (!arst_n)
    (active_q && any_s) |=> $stable(sel_q_o));
endmodule

// File: rtl/por_pulse.sv
module por_pulse #(
  parameter int HI_T = 480,
  parameter int LO_T = 4000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic trip_i,
  input  logic sel_i,
  output logic hold_o
);
  localparam int CW = $clog2(LO_T + 1);
  localparam logic [CW-1:0] HI_END = CW'(HI_T - 1);
  localparam logic [CW-1:0] LO_END = CW'(LO_T - 1);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == (sel_i ? HI_END : LO_END));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      hold_o <= 1'b1;
    end else if (!trip_i) begin
      cnt_q  <= '0;
      hold_o <= 1'b1;
    end else if (hold_o) begin
      if (at_end) hold_o <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  a_r1_release_after_trip: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(hold_o) |-> $past(trip_i));
endmodule

// File: rtl/pwr_reset_seq.sv
module pwr_reset_seq
  import por_pkg::*;
#(
  parameter int CLK_KHZ = 50000,
  parameter int N_IO    = 8
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            pg_reg_i,
  input  logic            pg_sat_i,
  input  logic            pg_main_i,
  input  logic            dly_sel_i,
  input  logic            cfg_done_i,
  input  logic [N_IO-1:0] user_oe_i,
  input  logic [2:0]      cfg_oe_i,
  output logic [N_IO-1:0] user_oe_o,
  output logic [2:0]      cfg_oe_o,
  output logic            por_hold_o,
  output logic            user_mode_o,
  output logic            ramp_fault_o,
  output logic            ramp_warn_o
);
  localparam int T_MIN = (CLK_KHZ / 20 > 0) ? CLK_KHZ / 20 : 1;
  localparam int T_REG = ms_ticks(CLK_KHZ, 5);
  localparam int T_HI  = ms_ticks(CLK_KHZ, 12);
  localparam int T_LO  = ms_ticks(CLK_KHZ, 100);

  logic [N_GRP-1:0] pg_raw, pg_s;
  logic             sel_q, trip, hold, mode_q;

  assign pg_raw[GRP_REG]  = pg_reg_i;
  assign pg_raw[GRP_SAT]  = pg_sat_i;
  assign pg_raw[GRP_MAIN] = pg_main_i;

  por_sync #(.W(N_GRP)) u_sync (
    .clk(clk), .arst_n(arst_n), .d_i(pg_raw), .q_o(pg_s)
  );

  por_ramp_mon #(.MIN_T(T_MIN), .REG_T(T_REG), .HI_T(T_HI), .LO_T(T_LO)) u_mon (
    .clk(clk), .arst_n(arst_n), .pg_s_i(pg_s), .sel_i(dly_sel_i),
    .sel_q_o(sel_q), .fault_o(ramp_fault_o), .warn_o(ramp_warn_o)
  );

  // regulator gated into the main result, then combined with satellite
  assign trip = pg_s[GRP_SAT] & (pg_s[GRP_MAIN] & pg_s[GRP_REG]);

  por_pulse #(.HI_T(T_HI), .LO_T(T_LO)) u_pulse (
    .clk(clk), .arst_n(arst_n), .trip_i(trip), .sel_i(sel_q), .hold_o(hold)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) mode_q <= 1'b0;
    else         mode_q <= trip & ~hold & cfg_done_i;
  end

  assign por_hold_o  = hold;
  assign user_mode_o = mode_q;
  assign user_oe_o   = user_oe_i & {N_IO{mode_q}};
  assign cfg_oe_o    = cfg_oe_i;

  a_r8_trip_loss_exits: assert property (@(posedge clk) disable iff (!arst_n)
    !trip |=> !mode_q);
  a_r7_mode_released: assert property (@(posedge clk) disable iff (!arst_n)
    mode_q |-> !hold);
endmodule

// File: tb/pwr_reset_seq_tb.sv
module pwr_reset_seq_tb;
  localparam int CLK_KHZ = 40;
  localparam int N_IO    = 8;
  localparam int P_HI    = 12 * CLK_KHZ;
  localparam int P_LO    = 100 * CLK_KHZ;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic pg_reg = 1'b0, pg_sat = 1'b0, pg_main = 1'b0;
  logic dly_sel = 1'b1, cfg_done = 1'b0;
  logic [N_IO-1:0] user_oe_i = 8'hA5;
  logic [2:0] cfg_oe_i = 3'b000;
  logic [N_IO-1:0] user_oe_o;
  logic [2:0] cfg_oe_o;
  logic por_hold, user_mode, fault, warn;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pwr_reset_seq #(.CLK_KHZ(CLK_KHZ), .N_IO(N_IO)) u_dut (
    .clk(clk), .arst_n(arst_n), .pg_reg_i(pg_reg), .pg_sat_i(pg_sat),
    .pg_main_i(pg_main), .dly_sel_i(dly_sel), .cfg_done_i(cfg_done),
    .user_oe_i(user_oe_i), .cfg_oe_i(cfg_oe_i), .user_oe_o(user_oe_o),
    .cfg_oe_o(cfg_oe_o), .por_hold_o(por_hold), .user_mode_o(user_mode),
    .ramp_fault_o(fault), .ramp_warn_o(warn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_off();
    pg_reg = 0; pg_sat = 0; pg_main = 0; cfg_done = 0;
    wait_cyc(5);
  endtask

  task automatic t_reset();
    check("R10 hold", por_hold, 1);
    check("R10 mode", user_mode, 0);
    check("R10 oe", user_oe_o, 0);
    check("R10 fault", fault, 0);
    check("R10 warn", warn, 0);
  endtask

  task automatic t_cfg_pass();
    cfg_oe_i = 3'b101; wait_cyc(1);
    check("R9 cfg oe unpowered", cfg_oe_o, 3'b101);
    cfg_oe_i = 3'b010; wait_cyc(1);
    check("R9 cfg oe change", cfg_oe_o, 3'b010);
  endtask

  task automatic t_normal_hi();
    dly_sel = 1;
    pg_reg = 1; wait_cyc(10);
    pg_sat = 1; wait_cyc(10);
    check("R1 two groups hold", por_hold, 1);
    pg_main = 1;
    wait_cyc(P_HI);
    check("R2 short pulse not yet", por_hold, 1);
    wait_cyc(4);
    check("R2 short pulse released", por_hold, 0);
    check("R4 no fault in time", fault, 0);
    check("R5 no warn spaced", warn, 0);
    check("R7 no done no mode", user_mode, 0);
    check("R7 no done oe off", user_oe_o, 0);
    cfg_done = 1; wait_cyc(2);
    check("R7 mode on", user_mode, 1);
    check("R7 oe pass", user_oe_o, user_oe_i);
    cfg_oe_i = 3'b111; wait_cyc(1);
    check("R9 cfg oe in user mode", cfg_oe_o, 3'b111);
  endtask

  task automatic t_drop();
    pg_sat = 0; wait_cyc(4);
    check("R8 oe off on drop", user_oe_o, 0);
    check("R8 mode off on drop", user_mode, 0);
    check("R8 hold again", por_hold, 1);
    all_off();
  endtask

  task automatic t_sel_latch();
    dly_sel = 0;
    pg_reg = 1; wait_cyc(5);
    dly_sel = 1;
    pg_sat = 1; wait_cyc(5);
    pg_main = 1;
    wait_cyc(P_HI + 10);
    check("R3 select latched low", por_hold, 1);
    wait_cyc(P_LO - P_HI - 12);
    check("R2 long pulse not yet", por_hold, 1);
    wait_cyc(6);
    check("R2 long pulse released", por_hold, 0);
    check("R4 no fault long", fault, 0);
    all_off();
  endtask

  task automatic t_fault_other();
    dly_sel = 1;
    pg_reg = 1; wait_cyc(P_HI - 10);
    check("R4 sat not yet late", fault, 0);
    wait_cyc(30);
    check("R4 sat late", fault, 1);
    pg_sat = 1; pg_main = 1; wait_cyc(10);
    check("R4 fault sticky", fault, 1);
    all_off();
    check("R6 fault cleared", fault, 0);
  endtask

  task automatic t_fault_reg();
    dly_sel = 1;
    pg_sat = 1; wait_cyc(5 * CLK_KHZ - 10);
    check("R4 reg not yet late", fault, 0);
    wait_cyc(30);
    check("R4 reg late", fault, 1);
    all_off();
    check("R6 cleared after reg fault", fault, 0);
  endtask

  task automatic t_warn();
    pg_reg = 1; pg_sat = 1; pg_main = 1; wait_cyc(5);
    check("R5 warn fast", warn, 1);
    check("R5 no fault fast", fault, 0);
    all_off();
    check("R6 warn cleared", warn, 0);
  endtask

  initial begin
    wait_cyc(3);
    arst_n = 1;
    wait_cyc(2);
    t_reset();
    t_cfg_pass();
    t_normal_hi();
    t_drop();
    t_sel_latch();
    t_fault_other();
    t_fault_reg();
    t_warn();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule